// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block sits in the feedback path of a frequency synthesizer. It divides a fast clock by a programmable total ratio of P×N + A, where P is the lower modulus of a dual-modulus prescaler. A is the swallow count and N is the main count. During each output cycle, the block first runs A prescaler periods of length P+1. It then runs the remaining N−A prescaler periods at length P. At the end of each complete division it emits a one-clock comparison pulse.

The prescaler is modelled inside the design as a synchronous divide-by-P / P+1 counter running on the fast clock. The swallow counter and the main counter advance on the prescaler's end-of-period tick. They also drive the modulus-control line. A select input picks one of two modulus pairs: 64/65 when it is 1, and 128/129 when it is 0.

Configuration inputs are sampled only at a division boundary or during reset. A host can change them at any time without disturbing the cycle in progress. Legal settings are 3 ≤ N ≤ 2047 and 0 ≤ A ≤ 127, with A < N.

Top module: `pswallow_divider`

## Requirements
- R1: In steady state, the distance between consecutive `fp` pulses is P×N + A clocks. P is 64 when `sel_small` is 1 and 128 when it is 0.
- R2: Within each division, `mod_ctrl` is high in the first state of the cycle exactly when A ≠ 0. It stays high for exactly A×(P+1) clocks in total. It changes level only at the end of a prescaler period.
- R3: With A = 0, `mod_ctrl` never goes high and the division lasts exactly P×N clocks.
- R4: A change of `swallow_a`, `main_n` or `sel_small` made in the middle of a division does not alter that division's length. The new values apply from the next division onward.
- R5: `fp` is high for a single clock once per division and never for two consecutive clocks.
- R6: While `rst` is high, `fp` is low and `mod_ctrl` equals (A ≠ 0) for the values on the inputs. The first division, counted from the first clock after `rst` falls, lasts P×N + A clocks.
- R7: The range extremes divide correctly: N = 3 gives 3P + A clocks, and A = 127 gives P×N + 127 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock (VCO-rate clock into the prescaler model) |
| rst | input | 1 | Synchronous active-high reset; loads the configuration |
| swallow_a | input | A_W (7) | Swallow count A, 0 to 127 |
| main_n | input | N_W (11) | Main count N, 3 to 2047 |
| sel_small | input | 1 | 1 selects the 64/65 pair, 0 selects the 128/129 pair |
| mod_ctrl | output | 1 | Modulus control: 1 = prescaler divides by P+1, 0 = by P |
| fp | output | 1 | One-clock comparison pulse per complete division |

## Verification
The assertions check the following on every cycle:
- `fp` is always a one-clock pulse, and it always follows the main counter's final prescaler tick.
- The modulus line moves only on a prescaler tick.
- The swallow counter holds between ticks.
- The held modulus select moves only at a boundary.
- The prescaler count stays within its range.

The division length, the number of clocks spent at P+1, and the deferral of a mid-cycle configuration change can only be shown by the bench's scenarios. Those scenarios measure whole division intervals across several modulus pairs, the A = 0 case, the range extremes, and reset.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int unsigned SWALLOW_W_DEF = 7;
  localparam int unsigned MAIN_W_DEF    = 11;
  localparam int unsigned P_SMALL_DEF   = 64;
  localparam int unsigned P_LARGE_DEF   = 128;

  typedef enum logic {
    MOD_BASE  = 1'b0,
    MOD_PLUS1 = 1'b1
  } modulus_e;
endpackage

// File: rtl/psw_cfg_stage.sv
module psw_cfg_stage (
  input  logic clk,
  input  logic rst,
  input  logic wrap,
  input  logic sel_in,
  output logic sel_eff
);
  logic sel_q;

  // Value in force for the division that starts at this edge
  assign sel_eff = (rst || wrap) ? sel_in : sel_q;

  always_ff @(posedge clk) begin
    sel_q <= sel_eff;
  end

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(sel_q)); // R4
endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler #(
  parameter int unsigned P_SMALL = 64,
  parameter int unsigned P_LARGE = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_small,
  input  logic plus1_nxt,
  output logic tick
);
  localparam int unsigned PC_W = $clog2(P_LARGE + 2);
  localparam logic [PC_W-1:0] BASE_SMALL = PC_W'(P_SMALL - 1);
  localparam logic [PC_W-1:0] BASE_LARGE = PC_W'(P_LARGE - 1);

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] reload;

  always_comb begin
    reload = sel_small ? BASE_SMALL : BASE_LARGE;
    if (plus1_nxt) reload = reload + 1'b1;
  end

  assign tick = (pc == '0);

  always_ff @(posedge clk) begin
    if (rst || tick) pc <= reload;
    else             pc <= pc - 1'b1;
  end

  AST_PC_BOUND: assert property (@(posedge clk) disable iff (rst)
    pc <= PC_W'(P_LARGE)); // R1
endmodule

// File: rtl/psw_counters.sv
module psw_counters
  import psw_pkg::*;
#(
  parameter int unsigned A_W = SWALLOW_W_DEF,
  parameter int unsigned N_W = MAIN_W_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [A_W-1:0] a_ld,
  input  logic [N_W-1:0] n_ld,
  output logic           wrap,
  output logic           plus1_nxt,
  output logic           mc
);
  localparam logic [N_W-1:0] N_LAST = N_W'(1);

  logic [A_W-1:0] a_cnt, a_nxt;
  logic [N_W-1:0] n_cnt, n_nxt;
  modulus_e       mod_q;

  assign wrap = tick && (n_cnt == N_LAST);

  always_comb begin
    a_nxt = a_cnt;
    n_nxt = n_cnt;
    if (rst || wrap) begin
      a_nxt = a_ld;
      n_nxt = n_ld;
    end else if (tick) begin
      n_nxt = n_cnt - 1'b1;
      if (a_cnt != '0) a_nxt = a_cnt - 1'b1;
    end
  end

  assign plus1_nxt = (a_nxt != '0);
  assign mc        = (mod_q == MOD_PLUS1);

  always_ff @(posedge clk) begin
    a_cnt <= a_nxt;
    n_cnt <= n_nxt;
    mod_q <= plus1_nxt ? MOD_PLUS1 : MOD_BASE;
  end

  AST_SWALLOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(a_cnt)); // R2
  AST_MAIN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    n_cnt != '0); // R7
endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider
  import psw_pkg::*;
#(
  parameter int unsigned A_W     = SWALLOW_W_DEF,
  parameter int unsigned N_W     = MAIN_W_DEF,
  parameter int unsigned P_SMALL = P_SMALL_DEF,
  parameter int unsigned P_LARGE = P_LARGE_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] swallow_a,
  input  logic [N_W-1:0] main_n,
  input  logic           sel_small,
  output logic           mod_ctrl,
  output logic           fp
);
  logic tick, wrap, plus1_nxt, sel_eff, fp_q;

  psw_cfg_stage u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wrap    (wrap),
    .sel_in  (sel_small),
    .sel_eff (sel_eff)
  );

  psw_counters #(.A_W(A_W), .N_W(N_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .a_ld      (swallow_a),
    .n_ld      (main_n),
    .wrap      (wrap),
    .plus1_nxt (plus1_nxt),
    .mc        (mod_ctrl)
  );

  psw_prescaler #(.P_SMALL(P_SMALL), .P_LARGE(P_LARGE)) u_pre (
    .clk       (clk),
    .rst       (rst),
    .sel_small (sel_eff),
    .plus1_nxt (plus1_nxt),
    .tick      (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) fp_q <= 1'b0;
    else     fp_q <= wrap;
  end

  assign fp = fp_q;

  AST_FP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fp |=> !fp); // R5
  AST_FP_AFTER_WRAP: assert property (@(posedge clk) disable iff (rst)
    wrap |=> fp); // R1
  AST_MC_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !$stable(mod_ctrl) |-> $past(tick)); // R2
endmodule

// File: tb/sim_pswallow_divider.sv
module sim_pswallow_divider;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  a_in = '0;
  logic [10:0] n_in = 11'd3;
  logic        sel_in = 1'b1;
  logic        mod_ctrl, fp;

  always #(CLK_PERIOD/2) clk = ~clk;

  pswallow_divider u0 (
    .clk(clk), .rst(rst), .swallow_a(a_in), .main_n(n_in),
    .sel_small(sel_in), .mod_ctrl(mod_ctrl), .fp(fp)
  );

  typedef struct {
    int    period;
    int    mcc;
    bit    first;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  task automatic check(bit ok, string tag, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic push(int a, int n, bit sel, int reps, string tag);
    int p = sel ? 64 : 128;
    for (int i = 0; i < reps; i++) begin
      exp_t it;
      it.period = p * n + a;
      it.mcc    = a * (p + 1);
      it.first  = (a != 0);
      it.tag    = tag;
      q.push_back(it);
    end
  endtask

  // Change config in the middle of the last queued division
  task automatic change(int a, int n, bit sel, int reps, string tag);
    wait (q.size() == 1);
    repeat (10) @(posedge clk);
    #1;
    q[q.size()-1].tag = {q[q.size()-1].tag, "+R4"};
    a_in = a[6:0]; n_in = n[10:0]; sel_in = sel;
    push(a, n, sel, reps, tag);
  endtask

  // Monitor / scoreboard
  int cnt = 0, mcc = 0;
  bit first_mc = 0, prev_fp = 0, double_pulse = 0;

  always @(negedge clk) begin
    if (rst) begin
      cnt = 0; mcc = 0; prev_fp = 0;
    end else begin
      if (fp) begin
        if (prev_fp) double_pulse = 1;
        if (q.size() == 0) check(0, "R5", "unexpected fp pulse", cnt, -1);
        else begin
          e = q.pop_front();
          check(cnt == e.period, e.tag, "division length", cnt, e.period);
          check(mcc == e.mcc, "R2", "clocks at P+1", mcc, e.mcc);
          check(first_mc == e.first, "R2", "mod_ctrl at cycle start",
                int'(first_mc), int'(e.first));
        end
        cnt = 0; mcc = 0;
      end
      if (cnt == 0) first_mc = mod_ctrl;
      cnt++;
      mcc += int'(mod_ctrl);
      prev_fp = fp;
    end
  end

  initial begin
    a_in = 7'd5; n_in = 11'd10; sel_in = 1'b1; rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(fp == 1'b0, "R6", "fp in reset", int'(fp), 0);
    check(mod_ctrl == 1'b1, "R6", "mod_ctrl in reset, A=5", int'(mod_ctrl), 1);
    push(5, 10, 1, 3, "R1");
    @(posedge clk); #1 rst = 1'b0;

    change(0,   7,   1, 2, "R3");
    change(3,   4,   0, 2, "R1");
    change(2,   3,   1, 2, "R7");
    change(127, 128, 1, 1, "R7");
    change(0,   3,   0, 2, "R3");
    change(9,   10,  0, 2, "R1");
    change(100, 300, 0, 1, "R1");

    wait (q.size() == 0);
    @(posedge clk); #1;
    rst = 1'b1; a_in = 7'd0; n_in = 11'd5; sel_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(fp == 1'b0, "R6", "fp in second reset", int'(fp), 0);
    check(mod_ctrl == 1'b0, "R6", "mod_ctrl in reset, A=0", int'(mod_ctrl), 0);
    push(0, 5, 1, 2, "R6");
    @(posedge clk); #1 rst = 1'b0;
    wait (q.size() == 0);
    repeat (5) @(posedge clk);
    check(!double_pulse, "R5", "fp high two clocks in a row", int'(double_pulse), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      check(0, "WATCHDOG", "run did not complete", q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule